// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Evaluator

This block decides, for each of up to eight CPUs, whether that CPU currently has at least one interrupt it could take. It combines the distributor's enable bits, line-state bits, trigger configuration and shared-interrupt routing with its own record of interrupts already in service. The result is one registered pending bit per CPU.

Interrupts 0 to 31 are private. Each CPU has its own bank of line, enable and in-service state for them. Interrupts from 32 up are shared, and each is routed to exactly one CPU by a one-hot routing column.

The block also follows interrupts through their life cycle:
- A delivery strobe names the CPU and interrupt being handed over.
- An end-of-service strobe names the CPU and interrupt being retired.
- A level-triggered interrupt that has been delivered is held in service. Its line is ignored until end-of-service clears it.
- An edge-triggered interrupt is latched on its line and consumed by delivery. It never enters the in-service state.

Top module: `irq_pend_eval`

## Requirements
- R1: For a private interrupt i (0..31) and CPU c, bit c*32+i of `prv_line` and bit c*32+i of `prv_en` both set make `pend[c]` 1. Clearing either bit removes that interrupt as a cause.
- R2: For a shared interrupt n = 32+j, `pend[c]` is 1 when three bits are all set: bit j of `shr_line`, bit j of `shr_en`, and bit c*NSHR+j of `shr_tgt`. A CPU whose routing bit for j is 0 does not see that interrupt.
- R3: While `dist_en` is 0, every bit of `pend` is 0 on the following clock.
- R4: `pend` is registered. A change on any input shows on `pend` after exactly one rising clock edge, and not before it.
- R5: Bit n of `cfg_edge` selects the trigger type: 1 means edge, 0 means level. Delivery of a level interrupt puts it in service. While it is in service, its line no longer makes any CPU pending, even when the line stays high.
- R6: End-of-service for a level interrupt takes it out of service. A line that is still high then makes its CPU pending again.
- R7: An edge interrupt is latched whenever its line is high, and stays pending after the line falls. Delivery clears the latch and does not put the interrupt in service, so a later line pulse is pending again.
- R8: If an edge interrupt's line is high in the same cycle as its delivery, the new event wins and the interrupt stays pending.
- R9: After reset, `pend` is 0, no interrupt is in service and no edge latch is set.
- R10: Private in-service state is banked per CPU. Delivering private interrupt i to CPU c masks that interrupt only for CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| prv_en | input | NCPU*32 | Banked private enables, bit c*32+i |
| prv_line | input | NCPU*32 | Banked private line states, bit c*32+i |
| shr_en | input | NIRQ-32 | Shared enables, bit j for interrupt 32+j |
| shr_line | input | NIRQ-32 | Shared line states |
| shr_tgt | input | NCPU*(NIRQ-32) | Routing, bit c*NSHR+j; one-hot over c |
| cfg_edge | input | NIRQ | Trigger type per interrupt, 1 = edge |
| dlv_vld | input | 1 | Delivery strobe |
| dlv_cpu | input | CW | CPU receiving the delivery |
| dlv_irq | input | IDW | Interrupt number delivered |
| eoi_vld | input | 1 | End-of-service strobe |
| eoi_cpu | input | CW | CPU retiring the interrupt |
| eoi_irq | input | IDW | Interrupt number retired |
| pend | output | NCPU | Registered per-CPU pending flags |

## Verification
Two sweeps cover the main function:
- The first sweep walks a single private source through every CPU bank and bit position, with and without its enable. This tells apart a bank or bit mix-up from a missing enable term.
- The second sweep walks every shared interrupt through every routing choice. This separates routing to the wrong CPU from a dropped routing term.

Directed sequences then test each lifecycle rule against an input pattern the others cannot explain:
- A level line is held high across delivery and end-of-service, which shows the masking and the release.
- A short edge pulse shows the latch, its consumption by delivery, and that the in-service state is never entered.
- A held edge line shows that a same-cycle event wins.
- A private delivery on one CPU with the same line high on another shows that the banks are separate.

// File: rtl/irq_pend_eval.sv
module irq_pend_eval #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dist_en,
  input  logic [NCPU*32-1:0]          prv_en,
  input  logic [NCPU*32-1:0]          prv_line,
  input  logic [NIRQ-33:0]            shr_en,
  input  logic [NIRQ-33:0]            shr_line,
  input  logic [NCPU*(NIRQ-32)-1:0]   shr_tgt,
  input  logic [NIRQ-1:0]             cfg_edge,
  input  logic                        dlv_vld,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] dlv_cpu,
  input  logic [$clog2(NIRQ)-1:0]     dlv_irq,
  input  logic                        eoi_vld,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] eoi_cpu,
  input  logic [$clog2(NIRQ)-1:0]     eoi_irq,
  output logic [NCPU-1:0]             pend
);
  localparam int NSHR = NIRQ - 32;
  localparam int NPRV = NCPU * 32;
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int IDW  = $clog2(NIRQ);
  localparam int SW   = (NSHR > 1) ? $clog2(NSHR) : 1;

  logic [NPRV-1:0] prv_lat, prv_act, prv_cfg, prv_dlv, prv_eoi, prv_cand;
  logic [NSHR-1:0] shr_lat, shr_act, shr_cfg, shr_dlv, shr_eoi, shr_cand;

  for (genvar c = 0; c < NCPU; c++) begin : g_prv_dec
    for (genvar i = 0; i < 32; i++) begin : g_bit
      assign prv_cfg[c*32+i] = cfg_edge[i];
      assign prv_dlv[c*32+i] = dlv_vld && dlv_cpu == CW'(c) && dlv_irq == IDW'(i);
      assign prv_eoi[c*32+i] = eoi_vld && eoi_cpu == CW'(c) && eoi_irq == IDW'(i);
    end
  end

  for (genvar j = 0; j < NSHR; j++) begin : g_shr_dec
    assign shr_cfg[j] = cfg_edge[32+j];
    assign shr_dlv[j] = dlv_vld && dlv_irq == IDW'(32 + j);
    assign shr_eoi[j] = eoi_vld && eoi_irq == IDW'(32 + j);
  end

  assign prv_cand = (prv_line | prv_lat) & prv_en & ~prv_act;
  assign shr_cand = (shr_line | shr_lat) & shr_en & ~shr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_lat <= '0;
      prv_act <= '0;
      shr_lat <= '0;
      shr_act <= '0;
    end else begin
      prv_lat <= prv_cfg & (prv_line | (prv_lat & ~prv_dlv));
      shr_lat <= shr_cfg & (shr_line | (shr_lat & ~shr_dlv));
      prv_act <= ~prv_cfg & ((prv_act & ~prv_eoi) | prv_dlv);
      shr_act <= ~shr_cfg & ((shr_act & ~shr_eoi) | shr_dlv);
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[c] <= 1'b0;
      else pend[c] <= dist_en &&
                      ((|prv_cand[c*32 +: 32]) || (|(shr_cand & shr_tgt[c*NSHR +: NSHR])));
    end
  end

  logic [SW-1:0] dsi, esi;
  assign dsi = SW'(dlv_irq - IDW'(32));
  assign esi = SW'(eoi_irq - IDW'(32));

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |=> pend == '0);

  p_level_dlv_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vld && dlv_irq >= IDW'(32) && !cfg_edge[dlv_irq]) |=> shr_act[$past(dsi)]);

  p_eoi_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && eoi_irq >= IDW'(32) && !cfg_edge[eoi_irq] &&
     !(dlv_vld && dlv_irq == eoi_irq)) |=> !shr_act[$past(esi)]);

  p_edge_no_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vld && dlv_irq >= IDW'(32) && cfg_edge[dlv_irq]) |=> !shr_act[$past(dsi)]);
endmodule

// File: tb/irq_pend_eval_test.sv
`timescale 1ns/1ps
module irq_pend_eval_test;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int NSHR = NIRQ - 32;

  logic clk = 0, rst_n = 0, dist_en = 0;
  logic [NCPU*32-1:0] prv_en = '0, prv_line = '0;
  logic [NSHR-1:0] shr_en = '0, shr_line = '0;
  logic [NCPU*NSHR-1:0] shr_tgt = '0;
  logic [NIRQ-1:0] cfg_edge = '0;
  logic dlv_vld = 0, eoi_vld = 0;
  logic [1:0] dlv_cpu = '0, eoi_cpu = '0;
  logic [5:0] dlv_irq = '0, eoi_irq = '0;
  logic [NCPU-1:0] pend;
  int total = 0, bad = 0;
  bit done = 0;

  irq_pend_eval #(.NCPU(NCPU), .NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .prv_en(prv_en), .prv_line(prv_line),
    .shr_en(shr_en), .shr_line(shr_line), .shr_tgt(shr_tgt), .cfg_edge(cfg_edge),
    .dlv_vld(dlv_vld), .dlv_cpu(dlv_cpu), .dlv_irq(dlv_irq),
    .eoi_vld(eoi_vld), .eoi_cpu(eoi_cpu), .eoi_irq(eoi_irq), .pend(pend));

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [NCPU-1:0] exp, input string req);
    total++;
    if (pend !== exp) begin
      bad++;
      $display("FAIL %s: pend=%b expected=%b", req, pend, exp);
    end
  endtask

  task automatic route(input int j, input int t);
    for (int c = 0; c < NCPU; c++) shr_tgt[c*NSHR + j] = (c == t);
  endtask

  task automatic deliver(input int cpu, input int irq);
    dlv_vld = 1; dlv_cpu = 2'(cpu); dlv_irq = 6'(irq);
    tick(); dlv_vld = 0; tick();
  endtask

  task automatic retire(input int cpu, input int irq);
    eoi_vld = 1; eoi_cpu = 2'(cpu); eoi_irq = 6'(irq);
    tick(); eoi_vld = 0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end

  initial begin
    shr_tgt[0 +: NSHR] = '1;
    tick(); tick();
    chk('0, "R9 reset");
    rst_n = 1; dist_en = 1;
    tick();
    chk('0, "R9 idle after reset");

    // R1 sweep over every bank and private bit
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < 32; i++) begin
        prv_line = '0; prv_en = '0;
        prv_line[c*32+i] = 1; prv_en[c*32+i] = 1;
        tick(); chk(4'(1 << c), "R1 private line and enable");
        prv_en[c*32+i] = 0;
        tick(); chk('0, "R1 private enable off");
      end
    prv_line = '0;

    // R2 sweep over every shared interrupt and routing choice
    for (int j = 0; j < NSHR; j++)
      for (int t = 0; t < NCPU; t++) begin
        shr_line = '0; shr_en = '0;
        route(j, t);
        shr_line[j] = 1; shr_en[j] = 1;
        tick(); chk(4'(1 << t), "R2 shared routed");
        shr_en[j] = 0;
        tick(); chk('0, "R2 shared enable off");
        route(j, 0);
      end
    shr_line = '0;

    // R4 one-edge latency
    shr_en[3] = 1; route(3, 1);
    @(negedge clk); shr_line[3] = 1;
    #1; chk('0, "R4 before edge");
    @(posedge clk); #1; chk(4'b0010, "R4 after one edge");

    // R3 global enable
    dist_en = 0; tick(); chk('0, "R3 disabled");
    dist_en = 1; tick(); chk(4'b0010, "R3 re-enabled");
    shr_line = '0; shr_en = '0; route(3, 0); tick();

    // R5 / R6 level in-service masking, shared irq 40
    route(8, 2); shr_en[8] = 1; shr_line[8] = 1;
    tick(); chk(4'b0100, "R5 level pending");
    deliver(2, 40); chk('0, "R5 masked while in service");
    tick(); chk('0, "R5 still masked");
    retire(2, 40); chk(4'b0100, "R6 released after end-of-service");
    shr_line = '0; shr_en = '0; route(8, 0); tick();

    // R10 private banks, irq 5 on CPUs 0 and 1
    prv_line[5] = 1; prv_en[5] = 1; prv_line[32+5] = 1; prv_en[32+5] = 1;
    tick(); chk(4'b0011, "R10 both banks");
    deliver(0, 5); chk(4'b0010, "R10 only bank 0 masked");
    retire(0, 5); chk(4'b0011, "R10 bank 0 released");
    prv_line = '0; prv_en = '0; tick();

    // R7 edge latch, shared irq 50
    cfg_edge[50] = 1; route(18, 1); shr_en[18] = 1;
    shr_line[18] = 1; tick(); shr_line[18] = 0; tick();
    chk(4'b0010, "R7 latched after pulse");
    deliver(1, 50); chk('0, "R7 delivery consumes latch");
    shr_line[18] = 1; tick(); shr_line[18] = 0; tick();
    chk(4'b0010, "R7 no in-service after edge delivery");
    deliver(1, 50); chk('0, "R7 consumed again");

    // R8 held edge line beats delivery
    shr_line[18] = 1; tick();
    deliver(1, 50); chk(4'b0010, "R8 event wins over delivery");
    shr_line[18] = 0; tick();
    deliver(1, 50); chk('0, "R8 cleared once line low");

    done = 1;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule